// File: doc/BRIEF.md
# SLC-96 Receive Data-Link Stack Capture

This block collects the F-bit stream of received SLC-96 superframes into a five-byte receive stack that a host reads. An external framer supplies each received F bit with a slot strobe, marks the last frame of each superframe with a one-cycle pulse, and reports whether superframe alignment is held. Alignment search is done in that framer and not here.

Each strobed bit enters a private working buffer. At a superframe boundary the buffer is copied to the host-visible stack, but only if alignment held for the whole superframe. The same edge raises a sticky ready flag and a one-cycle interrupt. The host clears the flag by reading the status. If the host does not read in time, the next publish replaces the data without notice.

Top module: `slc_rx_stack`

## Requirements
- R1: After reset the stack output is all zeros, and `rdy_o` and `irq_o` are low.
- R2: Bits shift in MSB first. Of the 40 bits strobed in a superframe, the first lands in bit 7 of stack byte 0 and the last in bit 0 of byte 4. Byte k is presented on `stack_o[8k+7:8k]`.
- R3: A publish happens on the edge that samples `sf_end_i` high with `sf_aligned_i` high, after a superframe in which alignment never dropped. It copies the working buffer, including a bit strobed in that same cycle, and the new stack appears one cycle after the pulse.
- R4: On each publish `rdy_o` goes high and `irq_o` pulses high for exactly one cycle. Both change on the same edge as the stack.
- R5: A cycle with `status_rd_i` high clears `rdy_o` on the next edge. If that cycle is also a publish, the set wins and `rdy_o` stays high.
- R6: When `sf_aligned_i` is low at `sf_end_i`, the stack, `rdy_o` and `irq_o` are left as they were. The superframe that starts at that boundary is also discarded.
- R7: A superframe during which `sf_aligned_i` was low in any cycle is discarded in full, even if alignment has returned by its end.
- R8: The superframe in progress when reset is released is treated as unaligned and is not published.
- R9: A publish overwrites stack data the host has not read, and `rdy_o` stays high.
- R10: `f_bit_i` is ignored in cycles when `f_strobe_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| f_bit_i | input | 1 | Received F bit |
| f_strobe_i | input | 1 | F-bit slot strobe |
| sf_end_i | input | 1 | One-cycle pulse marking the superframe end |
| sf_aligned_i | input | 1 | Superframe alignment held, from the framer |
| status_rd_i | input | 1 | Host read of the status; clears the ready flag |
| stack_o | output | 40 | Five stack bytes; byte k is on bits 8k+7 to 8k |
| rdy_o | output | 1 | Receive stack ready flag |
| irq_o | output | 1 | One-cycle receive stack interrupt |

## Verification
The assertions expect `sf_end_i` to be a single-cycle pulse coming from a framer whose alignment input is valid on every cycle, including the pulse cycle. The bench drives each superframe as exactly 40 strobes followed by, or overlapping with, one end pulse. It changes alignment only on negative clock edges and inserts unstrobed cycles with a toggling F bit, so the only data the block may capture is what passes on the strobes.

// File: rtl/slc_rx_pkg.sv
package slc_rx_pkg;
    localparam int unsigned DEF_BYTES  = 5;
    localparam int unsigned DEF_BYTE_W = 8;

    typedef struct packed {
        logic lost;
        logic rdy;
        logic irq;
    } flag_st_t;
endpackage

// File: rtl/slc_rx_shift.sv
module slc_rx_shift #(
    parameter int unsigned W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_i,
    input  logic         stb_i,
    output logic [W-1:0] nxt_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb_i) begin
            st_d.bits = {st_q.bits[W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nxt_o = st_d.bits;

    // R10: without a strobe the buffer holds
    p_no_shift_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(st_q.bits));
endmodule

// File: rtl/slc_rx_pub.sv
module slc_rx_pub
    import slc_rx_pkg::*;
#(
    parameter int unsigned W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sf_end_i,
    input  logic         aligned_i,
    input  logic         rd_i,
    input  logic [W-1:0] work_i,
    output logic [W-1:0] stack_o,
    output logic         rdy_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] stack;
        flag_st_t     fl;
    } pub_st_t;

    pub_st_t st_d, st_q;
    logic    publish;

    always_comb begin
        st_d    = st_q;
        publish = sf_end_i && aligned_i && !st_q.fl.lost;
        st_d.fl.irq = publish;
        if (sf_end_i) begin
            st_d.fl.lost = !aligned_i;
        end else if (!aligned_i) begin
            st_d.fl.lost = 1'b1;
        end
        if (publish) begin
            st_d.stack  = work_i;
            st_d.fl.rdy = 1'b1;
        end else if (rd_i) begin
            st_d.fl.rdy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.fl.lost <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stack_o = st_q.stack;
    assign rdy_o   = st_q.fl.rdy;
    assign irq_o   = st_q.fl.irq;

    // R6: nothing is published while unaligned
    p_hold_unaligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned_i |=> ($stable(st_q.stack) && !st_q.fl.irq));
    // R4: the interrupt always comes with the ready flag
    p_irq_with_rdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fl.irq |-> st_q.fl.rdy);
    // R3: an interrupt follows a superframe end
    p_irq_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fl.irq |-> $past(sf_end_i));
    // R5: a read with no boundary clears the flag
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !sf_end_i) |=> !st_q.fl.rdy);
    // R4: the stack changes only together with the interrupt
    p_change_on_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.stack) |-> st_q.fl.irq);
endmodule

// File: rtl/slc_rx_stack.sv
module slc_rx_stack
    import slc_rx_pkg::*;
#(
    parameter int unsigned N_BYTES = DEF_BYTES,
    parameter int unsigned BYTE_W  = DEF_BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      f_bit_i,
    input  logic                      f_strobe_i,
    input  logic                      sf_end_i,
    input  logic                      sf_aligned_i,
    input  logic                      status_rd_i,
    output logic [N_BYTES*BYTE_W-1:0] stack_o,
    output logic                      rdy_o,
    output logic                      irq_o
);
    localparam int unsigned W = N_BYTES * BYTE_W;

    logic [W-1:0] work_nxt;
    logic [W-1:0] stack_raw;

    slc_rx_shift #(.W(W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (f_bit_i),
        .stb_i (f_strobe_i),
        .nxt_o (work_nxt)
    );

    slc_rx_pub #(.W(W)) u_pub (
        .clk       (clk),
        .rst_n     (rst_n),
        .sf_end_i  (sf_end_i),
        .aligned_i (sf_aligned_i),
        .rd_i      (status_rd_i),
        .work_i    (work_nxt),
        .stack_o   (stack_raw),
        .rdy_o     (rdy_o),
        .irq_o     (irq_o)
    );

    // first received byte becomes byte 0
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        assign stack_o[k*BYTE_W +: BYTE_W] = stack_raw[W-1-k*BYTE_W -: BYTE_W];
    end
endmodule

// File: tb/slc_rx_stack_tb.sv
module slc_rx_stack_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic f_bit = 1'b0, f_stb = 1'b0, sf_end = 1'b0, aligned = 1'b1, rd = 1'b0;
    logic [39:0] stack;
    logic rdy, irq;
    int n_run = 0, n_fail = 0;
    logic [39:0] shown;

    always #5 clk = ~clk;

    slc_rx_stack u_dut (
        .clk(clk), .rst_n(rst_n), .f_bit_i(f_bit), .f_strobe_i(f_stb),
        .sf_end_i(sf_end), .sf_aligned_i(aligned), .status_rd_i(rd),
        .stack_o(stack), .rdy_o(rdy), .irq_o(irq)
    );

    function automatic logic [39:0] order(input logic [39:0] d);
        logic [39:0] r;
        for (int k = 0; k < 5; k++) r[8*k +: 8] = d[39-8*k -: 8];
        return r;
    endfunction

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 40 strobed bits with idle, toggling cycles between them; optional dip / last bit overlap
    task automatic send(input logic [39:0] d, input int dip_at, input bit last_with_end);
        for (int i = 39; i >= 0; i--) begin
            if (i == 0 && last_with_end) begin
                f_bit = d[0]; f_stb = 1'b1; sf_end = 1'b1;
                @(negedge clk);
                f_stb = 1'b0; sf_end = 1'b0;
                return;
            end
            f_bit = d[i]; f_stb = 1'b1;
            @(negedge clk);
            f_stb = 1'b0; f_bit = ~d[i];
            if (i == dip_at) aligned = 1'b0;
            @(negedge clk);
            aligned = 1'b1;
        end
    endtask

    task automatic end_sf(input logic al, input logic with_rd);
        aligned = al; rd = with_rd; sf_end = 1'b1;
        @(negedge clk);
        sf_end = 1'b0; rd = 1'b0; aligned = 1'b1;
    endtask

    task automatic t_reset;
        chk("R1 stack", stack, 40'h0);
        chk("R1 rdy", {39'h0, rdy}, 40'h0);
        chk("R1 irq", {39'h0, irq}, 40'h0);
    endtask

    task automatic t_first_discard;
        send(40'hFFFF_FFFF_FF, -1, 1'b0);
        end_sf(1'b1, 1'b0);
        chk("R8 irq", {39'h0, irq}, 40'h0);
        chk("R8 stack", stack, 40'h0);
    endtask

    task automatic t_basic;
        send(40'hA5_3C_0F_81_7E, -1, 1'b0);
        end_sf(1'b1, 1'b0);
        chk("R2 R3 stack", stack, order(40'hA5_3C_0F_81_7E));
        chk("R4 irq", {39'h0, irq}, 40'h1);
        chk("R4 rdy", {39'h0, rdy}, 40'h1);
        @(negedge clk);
        chk("R4 irq one cycle", {39'h0, irq}, 40'h0);
        chk("R10 idle toggles ignored", stack, order(40'hA5_3C_0F_81_7E));
        shown = 40'hA5_3C_0F_81_7E;
    endtask

    task automatic t_read;
        rd = 1'b1; @(negedge clk); rd = 1'b0;
        chk("R5 read clears", {39'h0, rdy}, 40'h0);
    endtask

    task automatic t_overwrite;
        send(40'h11_22_33_44_55, -1, 1'b0);
        end_sf(1'b1, 1'b0);
        send(40'hC3_96_5A_E7_18, -1, 1'b0);
        end_sf(1'b1, 1'b0);
        chk("R9 stack", stack, order(40'hC3_96_5A_E7_18));
        chk("R9 rdy", {39'h0, rdy}, 40'h1);
        shown = 40'hC3_96_5A_E7_18;
    endtask

    task automatic t_unaligned_end;
        rd = 1'b1; @(negedge clk); rd = 1'b0;
        send(40'h01_02_03_04_05, -1, 1'b0);
        end_sf(1'b0, 1'b0);
        chk("R6 stack", stack, order(shown));
        chk("R6 irq", {39'h0, irq}, 40'h0);
        chk("R6 rdy", {39'h0, rdy}, 40'h0);
        send(40'h0A_0B_0C_0D_0E, -1, 1'b0);
        end_sf(1'b1, 1'b0);
        chk("R6 next superframe", stack, order(shown));
        send(40'h6D_DB_B6_6D_DB, -1, 1'b0);
        end_sf(1'b1, 1'b0);
        chk("R6 recovery", stack, order(40'h6D_DB_B6_6D_DB));
        shown = 40'h6D_DB_B6_6D_DB;
    endtask

    task automatic t_mid_dip;
        send(40'hF0_E1_D2_C3_B4, 17, 1'b0);
        end_sf(1'b1, 1'b0);
        chk("R7 stack", stack, order(shown));
        chk("R7 irq", {39'h0, irq}, 40'h0);
    endtask

    task automatic t_overlap;
        send(40'h99_88_77_66_55, -1, 1'b0);
        end_sf(1'b1, 1'b0);
        chk("R5 rdy before", {39'h0, rdy}, 40'h1);
        rd = 1'b1;
        send(40'h12_34_56_78_9B, -1, 1'b1);
        rd = 1'b0;
        chk("R3 last bit with end", stack, order(40'h12_34_56_78_9B));
        chk("R5 set wins", {39'h0, rdy}, 40'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_first_discard();
        t_basic();
        t_read();
        t_overwrite();
        t_unaligned_end();
        t_mid_dip();
        t_overlap();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule